// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder

This block encodes a serial stream of information bits with a rate 1/2, constraint-length-6 convolutional code. Each bit offered with its valid strobe yields one two-bit code symbol one clock later. Both parity bits are taken over a six-bit window made of the current bit and the five bits held in a 32-state shift register. The two generator polynomials are fixed: 1+D+D^3+D^5 and 1+D^2+D^3+D^4+D^5.

To close a frame so that a trellis decoder can end in the zero state, the user raises a flush input for five cycles. Each flush cycle pushes a zero into the register and emits the symbol for that zero. Reset is synchronous and active high and returns the register to the all-zero state.

Top module: `conv_enc_r2`

## Requirements
- R1: While reset is high at a clock edge, the next cycle shows out_valid low, out_sym equal to 2'b00 and the shift register cleared to zero.
- R2: out_sym[1] is the XOR of the accepted bit and the bits accepted 1, 3 and 5 steps earlier (polynomial 1+D+D^3+D^5).
- R3: out_sym[0] is the XOR of the accepted bit and the bits accepted 2, 3, 4 and 5 steps earlier (polynomial 1+D^2+D^3+D^4+D^5).
- R4: The first-polynomial bit is out_sym[1] and the second-polynomial bit is out_sym[0], so the symbol "10" means out_sym = 2'b10.
- R5: A bit is accepted on a cycle where in_valid or flush is high. out_valid is high exactly one cycle after each accepted bit, so every accepted bit yields one symbol.
- R6: On a cycle with neither in_valid nor flush high, the shift register does not change. A sequence split by idle cycles encodes the same as the same sequence without gaps.
- R7: While flush is high, the accepted bit is 0 whatever in_bit holds. Five consecutive flush cycles leave the register all zero, so a following 1 gives 2'b11.
- R8: From the zero state, the inputs 1,0,1,1,0 give the symbols 11,10,10,10,10.
- R9: out_sym holds its last value on cycles where out_valid is low.
- R10: A reset in the middle of a stream discards the state, even when in_valid is high in the reset cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_bit carries an information bit this cycle |
| in_bit | input | 1 | Information bit |
| flush | input | 1 | Accept a zero bit this cycle; overrides in_bit |
| out_valid | output | 1 | out_sym holds a new code symbol |
| out_sym | output | 2 | Code symbol; bit 1 from the first polynomial, bit 0 from the second |

## Verification
The fixed five-bit vector catches swapped parity bits or a wrong tap. Swapped bits show as 01 where 10 is expected, and a wrong tap changes one of the later symbols. Idle gaps inside a sequence expose a register that shifts on every clock: the symbols after the gap no longer match an ungapped run. Flushing with in_bit held at 1 catches a design that lets the data bit through during termination, because the 2'b11 expected after five flushes would then be wrong. A reset raised together with in_valid catches a design that gives the data path priority over reset. A long random run against an independent delay-line model covers the other tap combinations.

// File: rtl/cenc_pkg.sv
package cenc_pkg;
  localparam int STATE_W = 5;
  localparam int WIN_W   = STATE_W + 1;
  localparam int N_OUT   = 2;
  // Window bit k carries the bit delayed by k steps; bit 0 is the current bit.
  // Entry 0 drives the most significant symbol bit.
  localparam logic [WIN_W-1:0] TAPS [N_OUT] = '{6'b101011, 6'b111101};
endpackage

// File: rtl/cenc_state_reg.sv
module cenc_state_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         din,
  output logic [W-1:0] state_o
);
  // state_o[0] holds the most recent bit, state_o[W-1] the oldest.
  always_ff @(posedge clk) begin
    if (rst)
      state_o <= '0;
    else if (adv)
      state_o <= {state_o[W-2:0], din};
  end
endmodule

// File: rtl/cenc_parity.sv
module cenc_parity #(
  parameter int         W    = 6,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic [W-1:0] win_i,
  output logic         par_o
);
  assign par_o = ^(win_i & MASK);
endmodule

// File: rtl/cenc_out_reg.sv
module cenc_out_reg #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_i,
  input  logic [N-1:0] sym_i,
  output logic         v_o,
  output logic [N-1:0] sym_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_o   <= 1'b0;
      sym_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i)
        sym_o <= sym_i;
    end
  end
endmodule

// File: rtl/conv_enc_r2.sv
module conv_enc_r2
  import cenc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             flush,
  output logic             out_valid,
  output logic [N_OUT-1:0] out_sym
);
  logic               accept;
  logic               din;
  logic [STATE_W-1:0] state_q;
  logic [WIN_W-1:0]   window;
  logic [N_OUT-1:0]   code;

  assign accept = in_valid | flush;
  assign din    = in_bit & ~flush;
  assign window = {state_q, din};

  cenc_state_reg #(.W(STATE_W)) u_state (
    .clk     (clk),
    .rst     (rst),
    .adv     (accept),
    .din     (din),
    .state_o (state_q)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_par
    cenc_parity #(.W(WIN_W), .MASK(TAPS[k])) u_par (
      .win_i (window),
      .par_o (code[N_OUT-1-k])
    );
  end

  cenc_out_reg #(.N(N_OUT)) u_out (
    .clk   (clk),
    .rst   (rst),
    .v_i   (accept),
    .sym_i (code),
    .v_o   (out_valid),
    .sym_o (out_sym)
  );
endmodule

// File: rtl/cenc_chk.sv
module cenc_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       flush,
  input logic       out_valid,
  input logic [1:0] out_sym,
  input logic [4:0] state_q
);
  // R1, R10: reset wins over everything and clears output and state
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sym == 2'b00 && state_q == 5'd0));

  // R5: each accepted bit gives a valid symbol one cycle later
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (in_valid || flush) |=> out_valid);

  // R5: no symbol without an accepted bit
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(in_valid || flush) |=> !out_valid);

  // R6: the register is frozen on idle cycles
  a_r6_state_frozen: assert property (@(posedge clk) disable iff (rst)
    !(in_valid || flush) |=> $stable(state_q));

  // R7: a flush cycle shifts a zero into the register
  a_r7_flush_zero: assert property (@(posedge clk) disable iff (rst)
    flush |=> (state_q[0] == 1'b0));

  // R9: the symbol holds while out_valid is low
  a_r9_sym_hold: assert property (@(posedge clk) disable iff (rst)
    !(in_valid || flush) |=> $stable(out_sym));
endmodule

bind conv_enc_r2 cenc_chk u_cenc_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .flush     (flush),
  .out_valid (out_valid),
  .out_sym   (out_sym),
  .state_q   (state_q)
);

// File: tb/test_conv_enc_r2.sv
module test_conv_enc_r2;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       in_bit;
  logic       flush;
  logic       out_valid;
  logic [1:0] out_sym;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // model: d[k] = bit accepted k steps ago
  logic       d1, d2, d3, d4, d5;
  logic [1:0] last_sym;

  localparam int NV = 5;
  localparam logic       VIN  [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [1:0] VEXP [NV] = '{2'b11, 2'b10, 2'b10, 2'b10, 2'b10};

  always #10 clk = ~clk;

  conv_enc_r2 i_conv_enc_r2 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .flush     (flush),
    .out_valid (out_valid),
    .out_sym   (out_sym)
  );

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual valid/sym=%b expected %b", req, act, exp);
    end
  endtask

  task automatic model_reset();
    {d1, d2, d3, d4, d5} = '0;
    last_sym = 2'b00;
  endtask

  // Drive one cycle at a negedge; compare at the next negedge.
  task automatic cyc(string req, logic v, logic b, logic f);
    logic       u;
    logic [1:0] e;
    logic       ev;
    in_valid = v; in_bit = b; flush = f;
    ev = v | f;
    if (ev) begin
      u = f ? 1'b0 : b;
      e[1] = u ^ d1 ^ d3 ^ d5;
      e[0] = u ^ d2 ^ d3 ^ d4 ^ d5;
      {d5, d4, d3, d2, d1} = {d4, d3, d2, d1, u};
      last_sym = e;
    end
    @(negedge clk);
    check(req, {out_valid, out_sym}, {ev, last_sym});
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0; flush = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", {out_valid, out_sym}, 3'b000);
    model_reset();
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0; flush = 1'b0;
    model_reset();
    @(negedge clk);
    do_reset();

    // R8, R4: fixed vector from the zero state, table walk
    for (int i = 0; i < NV; i++) begin
      cyc("R8", 1'b1, VIN[i], 1'b0);
      check("R4", {out_valid, out_sym}, {1'b1, VEXP[i]});
    end

    // R6, R9: same vector with idle gaps must give the same symbols
    do_reset();
    cyc("R8", 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) cyc("R9", 1'b0, 1'b1, 1'b0);
    check("R9", {out_valid, out_sym}, 3'b011);
    cyc("R6", 1'b1, 1'b0, 1'b0);
    check("R6", {out_valid, out_sym}, 3'b110);
    cyc("R6", 1'b0, 1'b0, 1'b0);
    cyc("R6", 1'b1, 1'b1, 1'b0);
    check("R6", {out_valid, out_sym}, 3'b110);

    // R2, R3, R5: random stream against the delay-line model
    for (int i = 0; i < 400; i++) begin
      cyc("R2/R3/R5", ($urandom % 4) != 0, 1'($urandom), ($urandom % 16) == 0);
    end

    // R7: five flushes with in_bit held high terminate to zero
    cyc("R7", 1'b1, 1'b1, 1'b0);
    cyc("R7", 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) cyc("R7", 1'b0, 1'b1, 1'b1);
    cyc("R7", 1'b1, 1'b1, 1'b0);
    check("R7", {out_valid, out_sym}, 3'b111);
    cyc("R7", 1'b1, 1'b0, 1'b0);
    check("R7", {out_valid, out_sym}, 3'b110);

    // R10: reset mid-stream with in_valid high
    for (int i = 0; i < 4; i++) cyc("R10", 1'b1, 1'b1, 1'b0);
    rst = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
    @(negedge clk);
    check("R10", {out_valid, out_sym}, 3'b000);
    rst = 1'b0;
    model_reset();
    cyc("R10", 1'b1, 1'b1, 1'b0);
    check("R10", {out_valid, out_sym}, 3'b111);
    cyc("R10", 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule